// File: doc/BRIEF.md
# Iterative XOR/AND Adder with Completion Flag

This block adds two unsigned WIDTH-bit operands without any carry-propagate chain. On a start pulse the operands are captured into two working registers, each one bit wider than the operands. Every following clock cycle forms the bitwise XOR of the two registers as a partial sum and their bitwise AND as a carry vector. If the carry vector is zero, the XOR is the exact sum, the result is published and the done flag rises. If it is not zero, the XOR is written back into the first register and the carry vector, shifted left by one, is written into the second. Then the loop runs again.

The time to finish depends on the data. Operands with no set bits in common finish straight away. Long carry chains take up to WIDTH iterations. A counter reports how many shift iterations the last addition needed. Software or a sequencer pulses start, waits for done, and then reads the sum. The sum stays valid until the next start.

Top module: `iter_adder`

## Requirements
- R1: While rst_n (active low, asynchronous) is low, busy, done, sum and shifts are all 0. A start seen while busy is 0 captures both addends, and after that clock edge busy is 1, done is 0 and shifts is 0.
- R2: When done is 1, sum equals the exact (WIDTH+1)-bit sum of the two addends captured at the accepted start.
- R3: If the captured addends share no set bit (which includes either one being zero), done rises on the clock edge after the capture edge and shifts reads 0.
- R4: Each busy cycle with a nonzero carry replaces the first register with the XOR and the second with the carry shifted left by one, and adds one to shifts. The register pair's arithmetic sum is unchanged across that cycle. From capture to done takes shifts+1 clock edges, and shifts equals the number of iterations of that loop run on the operands.
- R5: shifts never exceeds WIDTH. Adding all-ones to 1 takes exactly WIDTH iterations.
- R6: Once done is 1, done, sum and shifts hold their values until the next start, even when the addend inputs change.
- R7: A start pulse while busy is 1 is ignored. The running addition finishes with its original operands.
- R8: Over random 8-bit operand pairs, the mean of shifts lies between 1.95 and 2.40 (expected about 2.16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load pulse, accepted only while idle |
| addend_a | input | WIDTH | First operand |
| addend_b | input | WIDTH | Second operand |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | Sum valid; held until the next start |
| sum | output | WIDTH+1 | Exact sum including the carry out |
| shifts | output | $clog2(WIDTH+1) | Number of shift iterations of the last addition |

## Verification
The bench checks every 6-bit operand pair, random 32-bit pairs and random 8-bit pairs. Each sum is compared with a plain addition, and each iteration count and latency with a loop model. Among the corner cases, a design that drops the top register bit would lose the carry out of all-ones plus one. A design that finishes one cycle late, or counts the final zero-carry check, would report a latency or count one too high. A design that reloads on a start during an addition would return the second pair's sum, and one that lets done or sum drift after completion would fail the hold checks while the addend inputs toggle.

// File: rtl/iadd_pkg.sv
package iadd_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } iadd_state_e;
endpackage

// File: rtl/iadd_halfcell.sv
module iadd_halfcell #(
   parameter int  W       = 33,
   parameter bit  PER_BIT = 1'b0
) (
   input  logic [W-1:0] op_x,
   input  logic [W-1:0] op_y,
   output logic [W-1:0] psum,
   output logic [W-1:0] pcarry
);
   generate
      if (PER_BIT) begin : g_cells
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign psum[i]   = op_x[i] ^ op_y[i];
            assign pcarry[i] = op_x[i] & op_y[i];
         end
      end else begin : g_vec
         assign psum   = op_x ^ op_y;
         assign pcarry = op_x & op_y;
      end
   endgenerate
endmodule

// File: rtl/iadd_carry_reg.sv
module iadd_carry_reg #(
   parameter int W = 33
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic [W-2:0] carry_in,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= load_val;
      else if (step) q <= {carry_in, 1'b0};
   end
endmodule

// File: rtl/iadd_iter_cnt.sv
module iadd_iter_cnt #(
   parameter int LIMIT = 32,
   parameter int CW    = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] TOP = CW'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     count <= '0;
      else if (clr)                   count <= '0;
      else if (inc && (count != TOP)) count <= count + 1'b1;
   end

   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= TOP);
endmodule

// File: rtl/iter_adder.sv
module iter_adder
   import iadd_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter bit PER_BIT  = 1'b0,
   parameter int CW       = $clog2(WIDTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [WIDTH-1:0] addend_a,
   input  logic [WIDTH-1:0] addend_b,
   output logic            busy,
   output logic            done,
   output logic [WIDTH:0]  sum,
   output logic [CW-1:0]   shifts
);
   localparam int RW = WIDTH + 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("iter_adder: WIDTH must be at least 1");
      end
      if (CW < $clog2(WIDTH + 1)) begin : g_bad_cw
         $error("iter_adder: CW too small for WIDTH");
      end
   endgenerate

   iadd_state_e state;
   logic [RW-1:0] a_q, b_q, x_w, c_w;
   logic          accept, step, carry_zero;

   assign accept     = start && (state == ST_IDLE);
   assign carry_zero = (c_w == '0);
   assign step       = (state == ST_RUN) && !carry_zero;
   assign busy       = (state == ST_RUN);

   iadd_halfcell #(.W(RW), .PER_BIT(PER_BIT)) u_cell (
      .op_x(a_q), .op_y(b_q), .psum(x_w), .pcarry(c_w)
   );

   iadd_carry_reg #(.W(RW)) u_breg (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val({1'b0, addend_b}),
      .step(step), .carry_in(c_w[RW-2:0]), .q(b_q)
   );

   iadd_iter_cnt #(.LIMIT(WIDTH), .CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(accept), .inc(step), .count(shifts)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         a_q   <= '0;
         done  <= 1'b0;
         sum   <= '0;
      end else if (accept) begin
         a_q   <= {1'b0, addend_a};
         done  <= 1'b0;
         state <= ST_RUN;
      end else if (state == ST_RUN) begin
         if (carry_zero) begin
            sum   <= x_w;
            done  <= 1'b1;
            state <= ST_IDLE;
         end else begin
            a_q <= x_w;
         end
      end
   end

   p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done && shifts == '0));

   p_disjoint_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && ((addend_a & addend_b) == '0)) |=> ##1 (done && shifts == '0));

   p_pair_sum_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !carry_zero) |=>
         ({1'b0, a_q} + {1'b0, b_q}) == $past({1'b0, a_q} + {1'b0, b_q}));

   p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(sum) && $stable(shifts)));

   p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (done || (shifts == $past(shifts) + 1'b1)));
endmodule

// File: tb/sim_iter_adder.sv
module sim_iter_adder;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   logic        s0_start = 0; logic [31:0] s0_a = 0, s0_b = 0;
   logic        s0_busy, s0_done; logic [32:0] s0_sum; logic [5:0] s0_cnt;
   logic        s1_start = 0; logic [5:0] s1_a = 0, s1_b = 0;
   logic        s1_busy, s1_done; logic [6:0] s1_sum; logic [2:0] s1_cnt;
   logic        s2_start = 0; logic [7:0] s2_a = 0, s2_b = 0;
   logic        s2_busy, s2_done; logic [8:0] s2_sum; logic [3:0] s2_cnt;

   iter_adder #(.WIDTH(32)) u0 (.clk(clk), .rst_n(rst_n), .start(s0_start),
      .addend_a(s0_a), .addend_b(s0_b), .busy(s0_busy), .done(s0_done),
      .sum(s0_sum), .shifts(s0_cnt));
   iter_adder #(.WIDTH(6), .PER_BIT(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .start(s1_start),
      .addend_a(s1_a), .addend_b(s1_b), .busy(s1_busy), .done(s1_done),
      .sum(s1_sum), .shifts(s1_cnt));
   iter_adder #(.WIDTH(8)) u2 (.clk(clk), .rst_n(rst_n), .start(s2_start),
      .addend_a(s2_a), .addend_b(s2_b), .busy(s2_busy), .done(s2_done),
      .sum(s2_sum), .shifts(s2_cnt));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ref_shifts(input longint a, input longint b);
      longint x = a, y = b, c;
      int n = 0;
      while ((x & y) != 0) begin
         c = (x & y) << 1;
         x = x ^ y;
         y = c;
         n++;
      end
      return n;
   endfunction

   task automatic put(input int w, input bit st, input logic [31:0] a, input logic [31:0] b);
      case (w)
         6:       begin s1_start = st; s1_a = a[5:0]; s1_b = b[5:0]; end
         8:       begin s2_start = st; s2_a = a[7:0]; s2_b = b[7:0]; end
         default: begin s0_start = st; s0_a = a;      s0_b = b;      end
      endcase
   endtask

   function automatic bit get_done(input int w);
      return (w == 6) ? s1_done : (w == 8) ? s2_done : s0_done;
   endfunction
   function automatic bit get_busy(input int w);
      return (w == 6) ? s1_busy : (w == 8) ? s2_busy : s0_busy;
   endfunction
   function automatic longint get_sum(input int w);
      return (w == 6) ? longint'(s1_sum) : (w == 8) ? longint'(s2_sum) : longint'(s0_sum);
   endfunction
   function automatic int get_cnt(input int w);
      return (w == 6) ? int'(s1_cnt) : (w == 8) ? int'(s2_cnt) : int'(s0_cnt);
   endfunction

   // full add with checks of R1, R2, R3, R4, R5
   task automatic op(input int w, input logic [31:0] a, input logic [31:0] b, output int cnt);
      longint ea = longint'(a), eb = longint'(b), es;
      int ex, lat;
      if (w == 6) begin ea = ea & 63; eb = eb & 63; end
      if (w == 8) begin ea = ea & 255; eb = eb & 255; end
      es = ea + eb;
      ex = ref_shifts(ea, eb);
      @(negedge clk); put(w, 1'b1, a, b);
      @(negedge clk); put(w, 1'b0, a, b);
      chk(get_busy(w) && !get_done(w) && get_cnt(w) == 0, "R1 load", get_busy(w), 1);
      lat = 0;
      while (!get_done(w) && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      cnt = get_cnt(w);
      chk(get_sum(w) == es, "R2 sum", get_sum(w), es);
      chk(cnt == ex, "R4 count", cnt, ex);
      chk(lat == ex + 1, "R4 latency", lat, ex + 1);
      chk(cnt <= w, "R5 bound", cnt, w);
      if ((ea & eb) == 0) chk(lat == 1 && cnt == 0, "R3 disjoint", lat, 1);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int c;
      longint held;
      real acc;
      void'($urandom(32'd20240611));
      #1;
      chk(s0_busy == 0 && s0_done == 0 && s0_sum == 0 && s0_cnt == 0, "R1 reset", s0_done, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // directed 32-bit corners
      op(32, 32'h0, 32'h1234_5678, c);                 // R3 zero operand
      op(32, 32'hAAAA_AAAA, 32'h5555_5555, c);         // R3 disjoint
      op(32, 32'hFFFF_FFFF, 32'h1, c);                 // R5 longest chain
      chk(c == 32, "R5 full width", c, 32);
      chk(s0_sum == 33'h1_0000_0000, "R2 carry out", longint'(s0_sum), 64'h1_0000_0000);
      op(32, 32'hFFFF_FFFF, 32'hFFFF_FFFF, c);

      // R6: hold with changing inputs, no start
      held = longint'(s0_sum);
      c = s0_cnt;
      @(negedge clk); put(32, 1'b0, 32'h1, 32'h3);
      repeat (3) @(negedge clk);
      chk(s0_done && longint'(s0_sum) == held && int'(s0_cnt) == c, "R6 hold", longint'(s0_sum), held);

      // R7: start during busy is ignored
      @(negedge clk); put(32, 1'b1, 32'hFFFF_FFFF, 32'h1);
      @(negedge clk); put(32, 1'b0, 32'h0, 32'h0);
      repeat (2) @(negedge clk);
      put(32, 1'b1, 32'h5, 32'h5);
      @(negedge clk); put(32, 1'b0, 32'h0, 32'h0);
      chk(s0_busy == 1, "R7 still busy", s0_busy, 1);
      while (!s0_done) @(negedge clk);
      chk(s0_sum == 33'h1_0000_0000 && s0_cnt == 32, "R7 original result", longint'(s0_sum), 64'h1_0000_0000);

      // random 32-bit
      for (int i = 0; i < 400; i++) op(32, $urandom, $urandom, c);

      // exhaustive 6-bit
      for (int a = 0; a < 64; a++)
         for (int b = 0; b < 64; b++) op(6, a, b, c);

      // R8 average at 8 bits
      acc = 0.0;
      for (int i = 0; i < 2000; i++) begin
         op(8, $urandom & 32'hFF, $urandom & 32'hFF, c);
         acc += c;
      end
      acc = acc / 2000.0;
      chk(acc > 1.95 && acc < 2.40, "R8 average x1000", longint'(acc * 1000.0), 2158);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule